// File: doc/BRIEF.md
# Seconds-Resolution Wake-Up Timer Core

This block measures relative time in whole seconds. A free-running prescaler divides the 32.768 kHz input clock into a one-second count enable. A 24-bit up-counter advances on that enable and is compared against a 24-bit wake-up value. When the two agree, the block raises its interrupt and freezes the counter on the matching value. If no wake-up value has been loaded since reset, the counter runs to all-ones and parks there without interrupting.

The block sits behind a serial register interface and a reset debouncer. Both are outside it. It sees only three things: a clean active-low reset level, a one-cycle write strobe carrying a complete 24-bit wake-up value, and a one-cycle snapshot strobe issued when a read begins.

Loading a wake-up value restarts the measurement. It clears both the counter and the prescaler phase, so the first second after a load is a full second. A load is accepted in every state.

The snapshot strobe copies the live count into a holding register. The bytes then read out all come from the same instant.

Top module: `wake_timer_core`

## Requirements
- R1: While running, the counter increases by exactly one every TICK_DIV clock cycles and never by more.
- R2: While rst_n is low, the count, the wake-up value, the snapshot, irq_o and armed_o are all zero, and run_o is high.
- R3: After rst_n rises, the count stays 0 for TICK_DIV-1 rising edges and becomes 1 on the TICK_DIV-th rising edge.
- R4: With armed_o high, a count equal to the wake-up value sets irq_o on the next edge, and the count holds that value.
- R5: With armed_o low, the counter stops at all-ones and sat_o rises, while irq_o stays low.
- R6: A write strobe makes the following take effect on the next edge: the wake-up value is loaded, armed_o is set, the count and prescaler are cleared, and run_o is high. This holds in every state. With no write, the wake-up value does not change.
- R7: Once halted (irq_o or sat_o high), the count and flags stay unchanged until a write or a reset. A snapshot request does not alter them.
- R8: A wake-up value of zero left by reset never matches: the count passes zero without raising irq_o.
- R9: A snapshot strobe captures the count present at that edge. The snapshot holds until the next strobe.
- R10: Writing zero as the wake-up value raises irq_o two edges after the strobe, with the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timing clock |
| rst_n | input | 1 | Debounced active-low reset, asynchronous assert |
| wr_en | input | 1 | One-cycle wake-up value load strobe |
| wr_data | input | CNT_W | Complete wake-up value to load |
| snap_req | input | 1 | One-cycle snapshot strobe at start of a read |
| count_o | output | CNT_W | Live seconds count |
| wake_o | output | CNT_W | Current wake-up value |
| snap_o | output | CNT_W | Count captured by the last snapshot |
| irq_o | output | 1 | High while halted on a match |
| armed_o | output | 1 | A wake-up value has been loaded since reset |
| run_o | output | 1 | Counter is in its counting state |
| sat_o | output | 1 | Counter is parked at all-ones, unarmed |

## Verification
The hardest state to reach from the ports is the unarmed saturation stop. At full width it needs 2^24 seconds, and each second is 32768 clocks. The bench therefore elaborates the core with a 6-bit counter and a divide-by-4 prescaler. That brings all-ones within a few hundred cycles while keeping every ordering rule intact. The same short seconds let the bench hit the zero-value write and mid-run reloads on exact edges.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_HIT = 2'd1,
    ST_SAT = 2'd2
  } wt_state_e;

  // Compare gated by the armed flag.
  function automatic logic wt_hit(input logic armed, input logic [63:0] cnt, input logic [63:0] wake);
    return armed && (cnt == wake);
  endfunction

  // Final count reached without a loaded wake-up value.
  function automatic logic wt_top(input logic armed, input logic [63:0] cnt, input logic [63:0] maxv);
    return !armed && (cnt == maxv);
  endfunction
endpackage

// File: rtl/wt_second_tick.sv
module wt_second_tick #(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] phase;

  assign tick_o = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart_i || tick_o) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/wt_seq.sv
module wt_seq
  import wt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] wake_o,
  output logic             armed_o,
  output wt_state_e        state_o,
  output logic             hit_o,
  output logic             top_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] count_q, wake_q;
  logic             armed_q;
  wt_state_e        state_q;

  assign hit_o = (state_q == ST_RUN) && wt_hit(armed_q, 64'(count_q), 64'(wake_q));
  assign top_o = (state_q == ST_RUN) && wt_top(armed_q, 64'(count_q), 64'(MAXV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      wake_q  <= '0;
      armed_q <= 1'b0;
      state_q <= ST_RUN;
    end else if (wr_en_i) begin
      wake_q  <= wr_data_i;
      armed_q <= 1'b1;
      count_q <= '0;
      state_q <= ST_RUN;
    end else if (state_q == ST_RUN) begin
      if (hit_o) begin
        state_q <= ST_HIT;
      end else if (top_o) begin
        state_q <= ST_SAT;
      end else if (tick_i) begin
        count_q <= count_q + 1'b1;
      end
    end
  end

  assign count_o = count_q;
  assign wake_o  = wake_q;
  assign armed_o = armed_q;
  assign state_o = state_q;
endmodule

// File: rtl/wt_snapshot.sv
module wt_snapshot #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] snap_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_o <= '0;
    end else if (snap_i) begin
      snap_o <= count_i;
    end
  end
endmodule

// File: rtl/wake_timer_core.sv
module wake_timer_core
  import wt_pkg::*;
#(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             snap_req,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] wake_o,
  output logic [CNT_W-1:0] snap_o,
  output logic             irq_o,
  output logic             armed_o,
  output logic             run_o,
  output logic             sat_o
);
  // Named internal events
  logic      sec_tick;
  logic      match_evt;
  logic      top_evt;
  wt_state_e state;

  wt_second_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (wr_en),
    .tick_o    (sec_tick)
  );

  wt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (sec_tick),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .count_o   (count_o),
    .wake_o    (wake_o),
    .armed_o   (armed_o),
    .state_o   (state),
    .hit_o     (match_evt),
    .top_o     (top_evt)
  );

  wt_snapshot #(.CNT_W(CNT_W)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .snap_i  (snap_req),
    .count_i (count_o),
    .snap_o  (snap_o)
  );

  assign irq_o = (state == ST_HIT);
  assign run_o = (state == ST_RUN);
  assign sat_o = (state == ST_SAT);
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             snap_req,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] wake_o,
  input logic [CNT_W-1:0] snap_o,
  input logic             irq_o,
  input logic             armed_o,
  input logic             run_o,
  input logic             sat_o
);
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !wr_en) |=> (count_o == $past(count_o) || count_o == CNT_W'($past(count_o) + 1'b1))); // R1

  AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (armed_o && count_o == wake_o)); // R4

  AST_SAT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |-> (count_o == '1 && !armed_o && !irq_o)); // R5

  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count_o == '0 && run_o && armed_o && wake_o == $past(wr_data))); // R6

  AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wake_o)); // R6

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o || sat_o) && !wr_en) |=> ($stable(count_o) && $stable(irq_o) && $stable(sat_o))); // R7

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({run_o, irq_o, sat_o}) == 1); // R7

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (snap_o == $past(count_o))); // R9
endmodule

bind wake_timer_core wt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .snap_req (snap_req),
  .count_o  (count_o),
  .wake_o   (wake_o),
  .snap_o   (snap_o),
  .irq_o    (irq_o),
  .armed_o  (armed_o),
  .run_o    (run_o),
  .sat_o    (sat_o)
);

// File: tb/sim_wake_timer_core.sv
`timescale 1ns/1ps
module sim_wake_timer_core;
  localparam int W   = 6;
  localparam int DIV = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [W-1:0] wr_data;
  logic         snap_req;
  logic [W-1:0] count_o, wake_o, snap_o;
  logic         irq_o, armed_o, run_o, sat_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wake_timer_core #(.CNT_W(W), .TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .snap_req(snap_req),
    .count_o(count_o), .wake_o(wake_o), .snap_o(snap_o), .irq_o(irq_o),
    .armed_o(armed_o), .run_o(run_o), .sat_o(sat_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: elapsed-clock phase, seconds, mode 0=counting 1=matched 2=parked
  int m_phase = 0, m_sec = 0, m_wake = 0, m_snap = 0, m_mode = 0;
  bit m_loaded = 0;

  always @(posedge clk) begin
    bit second_done;
    second_done = (m_phase == DIV - 1);
    if (!rst_n) begin
      m_phase = 0; m_sec = 0; m_wake = 0; m_snap = 0; m_mode = 0; m_loaded = 0;
    end else begin
      if (snap_req) m_snap = m_sec;
      m_phase = (wr_en || second_done) ? 0 : m_phase + 1;
      if (wr_en) begin
        m_wake = int'(wr_data); m_loaded = 1; m_sec = 0; m_mode = 0;
      end else if (m_mode == 0) begin
        if (m_loaded && m_sec == m_wake)       m_mode = 1;
        else if (!m_loaded && m_sec == MAXV)   m_mode = 2;
        else if (second_done)                  m_sec = m_sec + 1;
      end
    end
    #1;
    chk("R1 count",  count_o,  m_sec);
    chk("R4 irq",    irq_o,    m_mode == 1);
    chk("R5 sat",    sat_o,    m_mode == 2);
    chk("R6 wake",   wake_o,   m_wake);
    chk("R7 run",    run_o,    m_mode == 0);
    chk("R8 armed",  armed_o,  m_loaded);
    chk("R9 snap",   snap_o,   m_snap);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int v);
    wr_en = 1'b1; wr_data = W'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic snap();
    snap_req = 1'b1;
    @(negedge clk);
    snap_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; snap_req = 1'b0;
    cyc(4);
    chk("R2 count", count_o, 0); chk("R2 wake", wake_o, 0);
    chk("R2 irq", irq_o, 0); chk("R2 armed", armed_o, 0); chk("R2 run", run_o, 1);
    rst_n = 1'b1;
    cyc(DIV - 1);
    chk("R3 before first second", count_o, 0);
    cyc(1);
    chk("R3 first second", count_o, 1);
    cyc(30);
    chk("R8 no irq at zero", irq_o, 0);
    chk("R8 count moved past zero", count_o >= 2, 1);

    load(3);
    chk("R6 cleared", count_o, 0); chk("R6 wake", wake_o, 3); chk("R6 armed", armed_o, 1);
    cyc(20);
    chk("R4 irq", irq_o, 1); chk("R4 held", count_o, 3);
    snap();
    chk("R9 snap in halt", snap_o, 3);
    cyc(10);
    chk("R7 hold count", count_o, 3); chk("R7 hold irq", irq_o, 1);

    load(5);
    chk("R6 irq cleared", irq_o, 0); chk("R6 restart", count_o, 0);
    cyc(8);
    snap();
    chk("R9 snap mid-run", snap_o, 2);
    load(9);
    chk("R6 reload mid-run", count_o, 0);
    cyc(50);
    chk("R4 irq 9", irq_o, 1); chk("R4 held 9", count_o, 9);

    load(0);
    chk("R10 not yet", irq_o, 0);
    cyc(1);
    chk("R10 irq", irq_o, 1); chk("R10 count", count_o, 0);

    rst_n = 1'b0;
    cyc(2);
    chk("R2 wake reset", wake_o, 0); chk("R2 armed reset", armed_o, 0); chk("R2 irq reset", irq_o, 0);
    rst_n = 1'b1;
    cyc(270);
    chk("R5 parked", count_o, MAXV); chk("R5 sat", sat_o, 1); chk("R5 no irq", irq_o, 0);
    snap();
    cyc(20);
    chk("R7 still parked", count_o, MAXV); chk("R7 still sat", sat_o, 1);
    chk("R9 snap parked", snap_o, MAXV);

    load(4);
    chk("R6 leave sat", sat_o, 0); chk("R6 run", run_o, 1); chk("R6 count", count_o, 0);
    cyc(25);
    chk("R4 irq 4", irq_o, 1); chk("R4 held 4", count_o, 4);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule